// File: doc/BRIEF.md
# Linear Page Table Walker

This block turns one virtual address into a physical address by reading a single entry of a flat, one-level page table held in memory. A requester presents a 32-bit virtual address, the base address of the current page table and the kind of access it wants to make: read, write or execute. The walker works out where the matching entry sits in the table and fetches it over one memory read port. It then checks the entry and returns one of three results: a physical address, a fault for an invalid entry, or a fault for an entry whose permissions forbid the access.

Pages are 4 KB and entries are 4 bytes. The virtual page number is the address shifted right by 12. The entry lies at the table base plus four times that page number. Entry bit 0 is the valid flag. Bits 1, 2 and 3 allow read, write and execute. Bits 31:12 hold the frame number. On success, the physical address is the frame number placed above the untouched 12-bit page offset.

The control is a five-state machine. IDLE accepts a request and goes to ISSUE_READ. ISSUE_READ holds the memory read request until the memory takes it, then goes to WAIT_DATA. WAIT_DATA captures the returned entry and goes to CHECK. CHECK registers the verdict and goes to DONE. DONE presents the result until the requester takes it, then returns to IDLE. Only one walk is in flight at a time.

Top module: `ptw_linear`

## Requirements
- R1: After reset, `req_ready` is 1 and both `mem_req_valid` and `rsp_valid` are 0.
- R2: The entry address on `mem_req_addr` equals the table base plus `vaddr[31:12]` times 4. Both the base and the address are sampled in the cycle the request is accepted, so later changes on those inputs have no effect on the walk.
- R3: `mem_req_valid` stays high, and `mem_req_addr` stays unchanged, in every cycle until `mem_req_ready` is seen. `mem_req_valid` drops in the cycle after that handshake.
- R4: If entry bit 0 (valid) is 0, the result has fault code 2'b01 and a physical address of 0, whatever the permission bits say.
- R5: If the entry is valid but does not permit the access, the result has fault code 2'b10 and a physical address of 0. Access code 0 (read) needs bit 1, code 1 (write) needs bit 2, code 2 (execute) needs bit 3, and code 3 is never permitted. Fault code 2'b11 never appears.
- R6: If the entry is valid and permits the access, the fault code is 2'b00 and `rsp_paddr` is entry bits 31:12 concatenated with `vaddr[11:0]`.
- R7: `req_ready` is 0 from the cycle after a request is accepted until the response handshake. It is 1 again in the cycle after that handshake.
- R8: While `rsp_valid` is high and `rsp_ready` is low, `rsp_valid`, `rsp_paddr` and `rsp_fault` hold their values.
- R9: `rsp_valid` rises two clock edges after the edge at which `mem_rsp_valid` delivers the entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Translation request present |
| req_ready | output | 1 | Walker can take a request |
| req_vaddr | input | 32 | Virtual address to translate |
| req_access | input | 2 | 0 read, 1 write, 2 execute, 3 reserved |
| req_ptbase | input | 32 | Page table base address |
| mem_req_valid | output | 1 | Memory read request |
| mem_req_ready | input | 1 | Memory accepts the read |
| mem_req_addr | output | 32 | Byte address of the entry |
| mem_rsp_valid | input | 1 | Entry data valid |
| mem_rsp_data | input | 32 | Entry data |
| rsp_valid | output | 1 | Result available |
| rsp_ready | input | 1 | Requester takes the result |
| rsp_paddr | output | 32 | Physical address, 0 on a fault |
| rsp_fault | output | 2 | 00 none, 01 invalid entry, 10 permission denied |

## Verification
The memory read request is due in the first cycle after acceptance. It must stay in place through any number of stall cycles, so the bench compares `mem_req_addr` at every stalled cycle and while the table base input is deliberately changed. The result is due exactly two edges after the entry is delivered. The bench records the expected cycle at the moment it hands over the entry, and the monitor compares that cycle against the one in which it first sees `rsp_valid`. The monitor then holds `rsp_ready` low for a scripted number of cycles to check that the result stays put, and checks that `req_ready` returns only in the cycle after the handshake.

// File: rtl/ptw_pkg.sv
package ptw_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ISSUE_READ,
        ST_WAIT_DATA,
        ST_CHECK,
        ST_DONE
    } ptw_state_e;

    typedef enum logic [1:0] {
        FLT_NONE    = 2'b00,
        FLT_INVALID = 2'b01,
        FLT_PROT    = 2'b10
    } ptw_fault_e;

    typedef enum logic [1:0] {
        ACC_READ  = 2'b00,
        ACC_WRITE = 2'b01,
        ACC_EXEC  = 2'b10,
        ACC_RSVD  = 2'b11
    } ptw_access_e;

    localparam int ENT_VALID_BIT = 0;
    localparam int ENT_READ_BIT  = 1;
    localparam int ENT_WRITE_BIT = 2;
    localparam int ENT_EXEC_BIT  = 3;
    localparam int ENT_FLAG_W    = 4;

endpackage

// File: rtl/ptw_addr_gen.sv
module ptw_addr_gen #(
    parameter int ADDR_W        = 32,
    parameter int PAGE_SHIFT    = 12,
    parameter int PTE_SIZE_LOG2 = 2
) (
    input  logic [ADDR_W-1:0] table_base,
    input  logic [ADDR_W-1:0] vaddr,
    output logic [ADDR_W-1:0] entry_addr
);
    localparam int VPN_W = ADDR_W - PAGE_SHIFT;

    logic [VPN_W-1:0]  vpn;
    logic [ADDR_W-1:0] vpn_ext;
    logic [PAGE_SHIFT-1:0] unused_offset;

    assign vpn           = vaddr[ADDR_W-1:PAGE_SHIFT];
    assign unused_offset = vaddr[PAGE_SHIFT-1:0];
    assign vpn_ext       = {{PAGE_SHIFT{1'b0}}, vpn};
    assign entry_addr    = table_base + (vpn_ext << PTE_SIZE_LOG2);

endmodule

// File: rtl/ptw_entry_check.sv
module ptw_entry_check
    import ptw_pkg::*;
#(
    parameter int ADDR_W     = 32,
    parameter int PAGE_SHIFT = 12
) (
    input  logic [ENT_FLAG_W-1:0]        flags,
    input  logic [ADDR_W-PAGE_SHIFT-1:0] frame,
    input  logic [1:0]                   access,
    input  logic [PAGE_SHIFT-1:0]        offset,
    output logic [1:0]                   fault,
    output logic [ADDR_W-1:0]            paddr
);
    logic permitted;

    always_comb begin
        unique case (ptw_access_e'(access))
            ACC_READ:  permitted = flags[ENT_READ_BIT];
            ACC_WRITE: permitted = flags[ENT_WRITE_BIT];
            ACC_EXEC:  permitted = flags[ENT_EXEC_BIT];
            default:   permitted = 1'b0;
        endcase
    end

    always_comb begin
        if (!flags[ENT_VALID_BIT]) begin
            fault = FLT_INVALID;
            paddr = '0;
        end else if (!permitted) begin
            fault = FLT_PROT;
            paddr = '0;
        end else begin
            fault = FLT_NONE;
            paddr = {frame, offset};
        end
    end

endmodule

// File: rtl/ptw_linear.sv
module ptw_linear
    import ptw_pkg::*;
#(
    parameter int ADDR_W        = 32,
    parameter int PAGE_SHIFT    = 12,
    parameter int PTE_SIZE_LOG2 = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [ADDR_W-1:0] req_vaddr,
    input  logic [1:0]        req_access,
    input  logic [ADDR_W-1:0] req_ptbase,
    output logic              mem_req_valid,
    input  logic              mem_req_ready,
    output logic [ADDR_W-1:0] mem_req_addr,
    input  logic              mem_rsp_valid,
    input  logic [ADDR_W-1:0] mem_rsp_data,
    output logic              rsp_valid,
    input  logic              rsp_ready,
    output logic [ADDR_W-1:0] rsp_paddr,
    output logic [1:0]        rsp_fault
);
    localparam int PFN_W = ADDR_W - PAGE_SHIFT;

    ptw_state_e state_q, state_d;

    logic [ADDR_W-1:0]     ent_addr_q;
    logic [ADDR_W-1:0]     ent_addr_d;
    logic [PAGE_SHIFT-1:0] off_q;
    logic [1:0]            acc_q;
    logic [ENT_FLAG_W-1:0] flags_q;
    logic [PFN_W-1:0]      pfn_q;
    logic [ADDR_W-1:0]     paddr_q, chk_paddr;
    logic [1:0]            fault_q, chk_fault;
    logic                  unused_ent_bits;

    assign unused_ent_bits = ^mem_rsp_data[PAGE_SHIFT-1:ENT_FLAG_W];

    ptw_addr_gen #(
        .ADDR_W        (ADDR_W),
        .PAGE_SHIFT    (PAGE_SHIFT),
        .PTE_SIZE_LOG2 (PTE_SIZE_LOG2)
    ) i_addr_gen (
        .table_base (req_ptbase),
        .vaddr      (req_vaddr),
        .entry_addr (ent_addr_d)
    );

    ptw_entry_check #(
        .ADDR_W     (ADDR_W),
        .PAGE_SHIFT (PAGE_SHIFT)
    ) i_entry_check (
        .flags  (flags_q),
        .frame  (pfn_q),
        .access (acc_q),
        .offset (off_q),
        .fault  (chk_fault),
        .paddr  (chk_paddr)
    );

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:       if (req_valid)     state_d = ST_ISSUE_READ;
            ST_ISSUE_READ: if (mem_req_ready) state_d = ST_WAIT_DATA;
            ST_WAIT_DATA:  if (mem_rsp_valid) state_d = ST_CHECK;
            ST_CHECK:                         state_d = ST_DONE;
            ST_DONE:       if (rsp_ready)     state_d = ST_IDLE;
            default:                          state_d = ST_IDLE;
        endcase
    end

    // Outputs decoded from state
    always_comb begin
        req_ready     = 1'b0;
        mem_req_valid = 1'b0;
        rsp_valid     = 1'b0;
        unique case (state_q)
            ST_IDLE:       req_ready     = 1'b1;
            ST_ISSUE_READ: mem_req_valid = 1'b1;
            ST_DONE:       rsp_valid     = 1'b1;
            default:       ;
        endcase
    end

    // Walk datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ent_addr_q <= '0;
            off_q      <= '0;
            acc_q      <= '0;
            flags_q    <= '0;
            pfn_q      <= '0;
            paddr_q    <= '0;
            fault_q    <= FLT_NONE;
        end else begin
            if (state_q == ST_IDLE && req_valid) begin
                ent_addr_q <= ent_addr_d;
                off_q      <= req_vaddr[PAGE_SHIFT-1:0];
                acc_q      <= req_access;
            end
            if (state_q == ST_WAIT_DATA && mem_rsp_valid) begin
                flags_q <= mem_rsp_data[ENT_FLAG_W-1:0];
                pfn_q   <= mem_rsp_data[ADDR_W-1:PAGE_SHIFT];
            end
            if (state_q == ST_CHECK) begin
                paddr_q <= chk_paddr;
                fault_q <= chk_fault;
            end
        end
    end

    assign mem_req_addr = ent_addr_q;
    assign rsp_paddr    = paddr_q;
    assign rsp_fault    = fault_q;

endmodule

// File: rtl/ptw_linear_chk.sv
module ptw_linear_chk
    import ptw_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_valid,
    input logic              req_ready,
    input logic              mem_req_valid,
    input logic              mem_req_ready,
    input logic [ADDR_W-1:0] mem_req_addr,
    input logic              mem_rsp_valid,
    input logic              rsp_valid,
    input logic              rsp_ready,
    input logic [ADDR_W-1:0] rsp_paddr,
    input logic [1:0]        rsp_fault,
    input ptw_state_e        state
);
    // R3
    mem_req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_valid && !mem_req_ready |=> mem_req_valid && $stable(mem_req_addr));

    // R3
    mem_req_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_valid && mem_req_ready |=> !mem_req_valid);

    // R8
    rsp_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid && !rsp_ready |=> rsp_valid && $stable(rsp_paddr) && $stable(rsp_fault));

    // R7
    busy_after_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && req_ready |=> !req_ready);

    // R7
    ready_after_rsp_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid && rsp_ready |=> req_ready);

    // R9
    rsp_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
        state == ST_WAIT_DATA && mem_rsp_valid |=> !rsp_valid ##1 rsp_valid);

    // R5
    fault_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> rsp_fault != 2'b11);

    // R4
    fault_zero_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid && rsp_fault != 2'b00 |-> rsp_paddr == '0);

endmodule

bind ptw_linear ptw_linear_chk #(.ADDR_W(ADDR_W)) i_ptw_linear_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .req_valid     (req_valid),
    .req_ready     (req_ready),
    .mem_req_valid (mem_req_valid),
    .mem_req_ready (mem_req_ready),
    .mem_req_addr  (mem_req_addr),
    .mem_rsp_valid (mem_rsp_valid),
    .rsp_valid     (rsp_valid),
    .rsp_ready     (rsp_ready),
    .rsp_paddr     (rsp_paddr),
    .rsp_fault     (rsp_fault),
    .state         (state_q)
);

// File: tb/test_ptw_linear.sv
module test_ptw_linear;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [31:0] req_vaddr = '0;
    logic [1:0]  req_access = '0;
    logic [31:0] req_ptbase = '0;
    logic        mem_req_valid;
    logic        mem_req_ready = 1'b0;
    logic [31:0] mem_req_addr;
    logic        mem_rsp_valid = 1'b0;
    logic [31:0] mem_rsp_data = '0;
    logic        rsp_valid;
    logic        rsp_ready = 1'b0;
    logic [31:0] rsp_paddr;
    logic [1:0]  rsp_fault;

    typedef struct {
        logic [31:0] pa;
        logic [1:0]  flt;
        int          rstall;
        string       req;
    } exp_t;

    exp_t sb_q[$];
    int   lat_q[$];
    int   cyc = 0;
    int   n_tests = 0;
    int   n_fail = 0;
    int   done_cnt = 0;
    bit   finished = 0;

    ptw_linear i_ptw_linear (
        .clk           (clk),
        .rst_n         (rst_n),
        .req_valid     (req_valid),
        .req_ready     (req_ready),
        .req_vaddr     (req_vaddr),
        .req_access    (req_access),
        .req_ptbase    (req_ptbase),
        .mem_req_valid (mem_req_valid),
        .mem_req_ready (mem_req_ready),
        .mem_req_addr  (mem_req_addr),
        .mem_rsp_valid (mem_rsp_valid),
        .mem_rsp_data  (mem_rsp_data),
        .rsp_valid     (rsp_valid),
        .rsp_ready     (rsp_ready),
        .rsp_paddr     (rsp_paddr),
        .rsp_fault     (rsp_fault)
    );

    always #(CLK_PERIOD/2) clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    task automatic check(input bit ok, input string r, input logic [31:0] act, input logic [31:0] expv);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h (cycle %0d)", r, act, expv, cyc);
        end
    endtask

    function automatic logic [1:0] exp_fault(input logic [31:0] ent, input logic [1:0] acc);
        logic ok;
        if (!ent[0]) return 2'b01;
        case (acc)
            2'd0:    ok = ent[1];
            2'd1:    ok = ent[2];
            2'd2:    ok = ent[3];
            default: ok = 1'b0;
        endcase
        return ok ? 2'b00 : 2'b10;
    endfunction

    // Driver: one walk, plays the memory side
    task automatic walk(input logic [31:0] va, input logic [1:0] acc, input logic [31:0] base,
                        input logic [31:0] ent, input int mstall, input int dly, input int rstall,
                        input string r);
        exp_t e;
        logic [31:0] exp_addr;
        int target;
        exp_addr = base + ((va >> 12) << 2);
        e.flt    = exp_fault(ent, acc);
        e.pa     = (e.flt == 2'b00) ? {ent[31:12], va[11:0]} : 32'h0;
        e.rstall = rstall;
        e.req    = r;
        sb_q.push_back(e);
        target = done_cnt + 1;

        @(negedge clk);
        req_valid = 1'b1; req_vaddr = va; req_access = acc; req_ptbase = base;
        @(negedge clk);
        req_valid = 1'b0; req_ptbase = ~base; req_vaddr = $urandom; req_access = 2'($urandom);
        // R2: entry address, sampled at acceptance
        check(mem_req_valid === 1'b1, "R2 read issued", 32'(mem_req_valid), 32'd1);
        check(mem_req_addr === exp_addr, "R2 entry address", mem_req_addr, exp_addr);
        check(req_ready === 1'b0, "R7 busy after accept", 32'(req_ready), 32'd0);
        for (int k = 0; k < mstall; k++) begin
            @(negedge clk);
            // R3: request held during memory stall
            check(mem_req_valid === 1'b1 && mem_req_addr === exp_addr, "R3 request held",
                  mem_req_addr, exp_addr);
        end
        mem_req_ready = 1'b1;
        @(negedge clk);
        mem_req_ready = 1'b0;
        check(mem_req_valid === 1'b0, "R3 request drops after handshake", 32'(mem_req_valid), 32'd0);
        for (int k = 0; k < dly; k++) begin
            @(negedge clk);
            check(req_ready === 1'b0 && rsp_valid === 1'b0, "R7 busy while waiting",
                  32'(req_ready), 32'd0);
        end
        mem_rsp_valid = 1'b1; mem_rsp_data = ent;
        lat_q.push_back(cyc + 2);
        @(negedge clk);
        mem_rsp_valid = 1'b0; mem_rsp_data = $urandom;
        while (done_cnt < target) @(negedge clk);
    endtask

    // Monitor: pops expected results and compares
    initial begin
        exp_t e;
        int lat;
        logic [31:0] p0;
        logic [1:0]  f0;
        forever begin
            @(negedge clk);
            if (rsp_valid === 1'b1) begin
                if (sb_q.size() == 0 || lat_q.size() == 0) begin
                    check(1'b0, "R7 unexpected response", 32'(rsp_valid), 32'd0);
                    rsp_ready = 1'b1; @(negedge clk); rsp_ready = 1'b0;
                end else begin
                    e = sb_q.pop_front();
                    lat = lat_q.pop_front();
                    // R9: response latency
                    check(cyc == lat, "R9 response cycle", 32'(cyc), 32'(lat));
                    check(req_ready === 1'b0, "R7 no accept while result pending", 32'(req_ready), 32'd0);
                    p0 = rsp_paddr; f0 = rsp_fault;
                    for (int k = 0; k < e.rstall; k++) begin
                        @(negedge clk);
                        // R8: held while not taken
                        check(rsp_valid === 1'b1 && rsp_paddr === p0 && rsp_fault === f0,
                              "R8 result held", rsp_paddr, p0);
                    end
                    check(rsp_fault === e.flt, {e.req, " fault code"}, 32'(rsp_fault), 32'(e.flt));
                    check(rsp_paddr === e.pa, {e.req, " physical address"}, rsp_paddr, e.pa);
                    rsp_ready = 1'b1;
                    @(negedge clk);
                    rsp_ready = 1'b0;
                    check(rsp_valid === 1'b0 && req_ready === 1'b1, "R7 ready after handover",
                          32'(req_ready), 32'd1);
                    done_cnt++;
                end
            end
        end
    end

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        check(1'b0, "watchdog expired", 32'(cyc), 32'd0);
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        check(req_ready === 1'b1, "R1 req_ready in reset", 32'(req_ready), 32'd1);
        check(mem_req_valid === 1'b0, "R1 mem_req_valid in reset", 32'(mem_req_valid), 32'd0);
        check(rsp_valid === 1'b0, "R1 rsp_valid in reset", 32'(rsp_valid), 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        check(req_ready === 1'b1 && rsp_valid === 1'b0, "R1 idle after reset", 32'(req_ready), 32'd1);

        // R6: valid read with read permission
        walk(32'h0040_3A5C, 2'd0, 32'h0010_0000, 32'h0ABC_D003, 0, 0, 0, "R6 read ok");
        // R5: write denied on read-only entry
        walk(32'h1234_5678, 2'd1, 32'h0020_0000, 32'h7777_7003, 2, 1, 1, "R5 write denied");
        // R6: execute permitted
        walk(32'h0000_0FFF, 2'd2, 32'h8000_0000, 32'hFFFF_F009, 1, 3, 2, "R6 exec ok");
        // R4: invalid entry despite all permissions
        walk(32'hDEAD_BEEF, 2'd0, 32'h0000_4000, 32'h5555_500E, 3, 0, 0, "R4 invalid entry");
        // R5: reserved access code never permitted
        walk(32'h0001_2345, 2'd3, 32'h0000_8000, 32'h1111_100F, 0, 2, 3, "R5 reserved access");
        // R2: top page number, table base near top of memory
        walk(32'hFFFF_FFFF, 2'd1, 32'hFFC0_0000, 32'h0000_1005, 4, 4, 0, "R6 top page write ok");
        // R6: execute denied then write ok on full-permission entry
        walk(32'h0000_0000, 2'd2, 32'h0000_0000, 32'h0004_5007, 0, 0, 4, "R5 exec denied");
        walk(32'h7000_0ABC, 2'd1, 32'h0003_0000, 32'hCAFE_F00F, 5, 1, 1, "R6 write ok");
        for (int i = 0; i < 30; i++) begin
            walk($urandom, 2'($urandom), $urandom, $urandom, $urandom_range(0, 4),
                 $urandom_range(0, 4), $urandom_range(0, 3), "R6 mixed walk");
        end
        repeat (2) @(negedge clk);
        check(sb_q.size() == 0, "R7 all results delivered", 32'(sb_q.size()), 32'd0);
        finish_run();
    end

endmodule